// File: doc/BRIEF.md
# AHB Burst Transaction Coverage Monitor

This block watches the control side of an AHB slave port and counts finished burst transactions by kind. A transaction starts on an accepted NONSEQ transfer. Its kind comes from the burst type and the transfer direction sampled on that starting beat. The transaction is finished only after every beat of the burst has been accepted and the last data phase has ended with an OKAY response. Per kind, the monitor keeps a saturating hit counter and a sticky covered bit. Per burst class, it keeps sticky bins for "a wait state was seen" and "a BUSY cycle was seen". It also keeps one sticky bin for each ordered pair of burst classes that ran back to back.

The monitor is passive. It checks neither protocol legality nor data. All its pins are plain level signals with no handshake, because nothing flows out of it as a stream. A regression environment reads the bitmaps and the bin total at the end of a run to judge transaction-level coverage, and can use them to bias its stimulus toward bins that are still empty.

Top module: `ahb_burst_cov`

## Requirements
- R1: While `rst_n` is low, every counter, every bitmap and `cov_total` are zero, and no earlier transaction is remembered for the pairing rule.
- R2: A beat is a cycle with `hsel` and `hready` both high and `htrans` equal to NONSEQ (2'b10) or SEQ (2'b11). A NONSEQ beat starts a candidate. Its class comes from `hburst` on that beat: 0 is single (class 0), 1 is INCR (class 1), 2 or 3 is four-beat (class 2), 4 or 5 is eight-beat (class 3), 6 or 7 is sixteen-beat (class 4). Its kind index is 2*class + `hwrite`.
- R3: A fixed-length candidate finishes on the first cycle with `hready` high and `hresp` OKAY (2'b00) after its last beat. On that cycle its kind counter advances by exactly one.
- R4: An INCR candidate finishes on the first cycle where `hready` is high, `hresp` is OKAY, and either a new NONSEQ beat or an idle slot occurs.
- R5: Any cycle with `hsel` high and `hresp` not OKAY discards the open candidate. Nothing is counted for it, and the pairing history is cleared.
- R6: A NONSEQ beat that arrives before a fixed-length candidate has all its beats abandons that candidate. It is not counted and does not pair with the new one.
- R7: Each `CNT_W`-bit kind counter stops at 2^CNT_W-1 and never wraps.
- R8: The kind's bit in `kind_cov` sets on its first finish and stays set until reset.
- R9: `wait_cov[class]` sets when a candidate of that class finishes after at least one cycle with `hsel` high and `hready` low while it was open.
- R10: `busy_cov[class]` sets when a candidate of that class finishes after at least one BUSY (2'b01) cycle with `hsel` high while it was open.
- R11: `pair_cov[5*A+B]` sets when a class-B candidate finishes and its NONSEQ came either on the finishing cycle of a class-A transaction or later with no idle slot in between. An idle slot is a cycle with `hready` high and either `hsel` low or `htrans` IDLE (2'b00).
- R12: `cov_total` equals the number of set bits across `kind_cov`, `wait_cov`, `busy_cov` and `pair_cov`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave selected |
| htrans | input | 2 | Transfer type |
| hready | input | 1 | Transfer ready |
| hresp | input | 2 | Slave response, 2'b00 is OKAY |
| hburst | input | 3 | Burst type |
| hwrite | input | 1 | Write when high |
| hit_cnt | output | 10*CNT_W | Kind counters, kind k at bits [k*CNT_W +: CNT_W] |
| kind_cov | output | 10 | Kind covered bitmap |
| wait_cov | output | 5 | Per-class wait bin |
| busy_cov | output | 5 | Per-class BUSY bin |
| pair_cov | output | 25 | Ordered class-pair bins |
| cov_total | output | 6 | Number of set bins |

## Verification
The bench builds the monitor with `CNT_W` set to 3. A counter then saturates at 7 after a short run of back-to-back single transfers, so the stop-at-maximum behaviour gets exercised without long traffic. Every other parameter keeps its default, so all ten kinds, the ten class variant bins and the twenty-five pair bins keep their full size. The stimulus covers wait states on a single transfer, BUSY inside a four-beat burst, an error response in mid-burst, an abandoned burst, and an idle slot that separates two transfers.

// File: rtl/ahbcov_pkg.sv
package ahbcov_pkg;
  localparam int NCLS  = 5;
  localparam int NKIND = 2 * NCLS;
  localparam int NPAIR = NCLS * NCLS;
  localparam int NBIN  = NKIND + 2 * NCLS + NPAIR;
  localparam int BIN_W = $clog2(NBIN + 1);

  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_BUSY = 2'b01;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;

  typedef enum logic [2:0] {
    CL_SINGLE = 3'd0,
    CL_INCR   = 3'd1,
    CL_B4     = 3'd2,
    CL_B8     = 3'd3,
    CL_B16    = 3'd4
  } bclass_t;

  typedef struct packed {
    logic    fire;
    bclass_t cls;
    logic    wr;
    logic    waited;
    logic    busied;
    logic    paired;
    bclass_t pcls;
  } done_t;

  function automatic bclass_t class_of(input logic [2:0] hb);
    case (hb)
      3'd0:       class_of = CL_SINGLE;
      3'd1:       class_of = CL_INCR;
      3'd2, 3'd3: class_of = CL_B4;
      3'd4, 3'd5: class_of = CL_B8;
      default:    class_of = CL_B16;
    endcase
  endfunction

  function automatic logic [4:0] beats_of(input bclass_t c);
    case (c)
      CL_SINGLE: beats_of = 5'd1;
      CL_B4:     beats_of = 5'd4;
      CL_B8:     beats_of = 5'd8;
      CL_B16:    beats_of = 5'd16;
      default:   beats_of = 5'd0;
    endcase
  endfunction

  function automatic logic [BIN_W-1:0] ones(input logic [NBIN-1:0] v);
    logic [BIN_W-1:0] n;
    n = '0;
    for (int i = 0; i < NBIN; i++) n = n + BIN_W'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/ahbcov_tracker.sv
module ahbcov_tracker
  import ahbcov_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsel,
  input  logic [1:0] htrans,
  input  logic       hready,
  input  logic [1:0] hresp,
  input  logic [2:0] hburst,
  input  logic       hwrite,
  output done_t      done
);
  logic       act_q, last_q, wr_q, wait_q, busy_q, pend_q, prev_ok_q;
  bclass_t    cls_q, pcls_q, prev_cls_q;
  logic [4:0] cnt_q;

  logic    beat, nseq, seqb, gap, err, is_incr, comp, wait_now, busy_now;
  bclass_t new_cls;

  always_comb begin
    beat     = hsel && hready && htrans[1];
    nseq     = beat && (htrans == TR_NSEQ);
    seqb     = beat && (htrans == TR_SEQ);
    gap      = hready && (!hsel || (htrans == TR_IDLE));
    err      = hsel && (hresp != 2'b00);
    is_incr  = (cls_q == CL_INCR);
    comp     = act_q && hready && !err && (is_incr ? (nseq || gap) : last_q);
    wait_now = act_q && hsel && !hready;
    busy_now = act_q && hsel && (htrans == TR_BUSY);
    new_cls  = class_of(hburst);
    done     = '{fire: comp, cls: cls_q, wr: wr_q, waited: wait_q,
                 busied: busy_q, paired: pend_q, pcls: pcls_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; last_q <= 1'b0; wr_q <= 1'b0;
      wait_q <= 1'b0; busy_q <= 1'b0; pend_q <= 1'b0; prev_ok_q <= 1'b0;
      cls_q <= CL_SINGLE; pcls_q <= CL_SINGLE; prev_cls_q <= CL_SINGLE;
      cnt_q <= '0;
    end else begin
      if (wait_now) wait_q <= 1'b1;
      if (busy_now) busy_q <= 1'b1;
      if (err) begin
        act_q     <= 1'b0;
        pend_q    <= 1'b0;
        prev_ok_q <= 1'b0;
      end else begin
        if (comp) prev_cls_q <= cls_q;
        if (nseq) begin
          act_q     <= 1'b1;
          cls_q     <= new_cls;
          wr_q      <= hwrite;
          cnt_q     <= 5'd1;
          last_q    <= (beats_of(new_cls) == 5'd1);
          wait_q    <= 1'b0;
          busy_q    <= 1'b0;
          pend_q    <= comp || prev_ok_q;
          pcls_q    <= comp ? cls_q : prev_cls_q;
          prev_ok_q <= 1'b0;
        end else begin
          if (comp) begin
            act_q     <= 1'b0;
            prev_ok_q <= !gap;
          end else if (gap) begin
            prev_ok_q <= 1'b0;
          end
          if (act_q && !comp && seqb && !is_incr && !last_q) begin
            cnt_q <= cnt_q + 5'd1;
            if (cnt_q + 5'd1 == beats_of(cls_q)) last_q <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ahbcov_bank.sv
module ahbcov_bank #(
  parameter int N     = 10,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_en,
  input  logic [IDX_W-1:0]   inc_idx,
  output logic [N*CNT_W-1:0] cnt,
  output logic [N-1:0]       cov
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  for (genvar k = 0; k < N; k++) begin : g_kind
    logic [CNT_W-1:0] c_q;
    logic             v_q;
    logic             hit;
    assign hit = inc_en && (inc_idx == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= '0;
        v_q <= 1'b0;
      end else if (hit) begin
        v_q <= 1'b1;
        if (c_q != TOP) c_q <= c_q + 1'b1;
      end
    end
    assign cnt[k*CNT_W +: CNT_W] = c_q;
    assign cov[k] = v_q;
  end
endmodule

// File: rtl/ahbcov_flags.sv
module ahbcov_flags #(
  parameter int N = 5,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  output logic [N-1:0]     flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   flags[i] <= 1'b0;
      else if (set_en && (set_idx == IDX_W'(i)))    flags[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/ahb_burst_cov.sv
module ahb_burst_cov
  import ahbcov_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hsel,
  input  logic [1:0]             htrans,
  input  logic                   hready,
  input  logic [1:0]             hresp,
  input  logic [2:0]             hburst,
  input  logic                   hwrite,
  output logic [NKIND*CNT_W-1:0] hit_cnt,
  output logic [NKIND-1:0]       kind_cov,
  output logic [NCLS-1:0]        wait_cov,
  output logic [NCLS-1:0]        busy_cov,
  output logic [NPAIR-1:0]       pair_cov,
  output logic [BIN_W-1:0]       cov_total
);
  localparam int KI_W = $clog2(NKIND);
  localparam int CI_W = $clog2(NCLS);
  localparam int PI_W = $clog2(NPAIR);

  done_t           d;
  logic [KI_W-1:0] kidx;
  logic [CI_W-1:0] cidx;
  logic [PI_W-1:0] pidx;

  ahbcov_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans), .hready(hready),
    .hresp(hresp), .hburst(hburst), .hwrite(hwrite), .done(d)
  );

  always_comb begin
    kidx = KI_W'(int'(d.cls) * 2 + int'(d.wr));
    cidx = CI_W'(d.cls);
    pidx = PI_W'(int'(d.pcls) * NCLS + int'(d.cls));
  end

  ahbcov_bank #(.N(NKIND), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .inc_en(d.fire), .inc_idx(kidx),
    .cnt(hit_cnt), .cov(kind_cov)
  );

  ahbcov_flags #(.N(NCLS)) u_wait (
    .clk(clk), .rst_n(rst_n), .set_en(d.fire && d.waited), .set_idx(cidx),
    .flags(wait_cov)
  );

  ahbcov_flags #(.N(NCLS)) u_busy (
    .clk(clk), .rst_n(rst_n), .set_en(d.fire && d.busied), .set_idx(cidx),
    .flags(busy_cov)
  );

  ahbcov_flags #(.N(NPAIR)) u_pair (
    .clk(clk), .rst_n(rst_n), .set_en(d.fire && d.paired), .set_idx(pidx),
    .flags(pair_cov)
  );

  assign cov_total = ones({pair_cov, busy_cov, wait_cov, kind_cov});
endmodule

// File: rtl/ahbcov_chk.sv
module ahbcov_chk
  import ahbcov_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NKIND*CNT_W-1:0] hit_cnt,
  input logic [NKIND-1:0]       kind_cov,
  input logic [NPAIR-1:0]       pair_cov,
  input logic [BIN_W-1:0]       cov_total
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  for (genvar k = 0; k < NKIND; k++) begin : g_k
    // R7: a full counter stays full
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hit_cnt[k*CNT_W +: CNT_W]) == TOP) |-> (hit_cnt[k*CNT_W +: CNT_W] == TOP));
    // R3: a counter moves by zero or one per cycle
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_cnt[k*CNT_W +: CNT_W] == $past(hit_cnt[k*CNT_W +: CNT_W])) ||
      (hit_cnt[k*CNT_W +: CNT_W] == $past(hit_cnt[k*CNT_W +: CNT_W]) + 1'b1));
  end

  a_r8_cov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind_cov & $past(kind_cov)) == $past(kind_cov)));

  a_r8_one_new_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kind_cov & ~$past(kind_cov)));

  a_r11_pair_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((pair_cov & $past(pair_cov)) == $past(pair_cov)));

  a_r11_one_new_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pair_cov & ~$past(pair_cov)));

  a_r12_total_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (cov_total >= $past(cov_total)) && ((cov_total - $past(cov_total)) <= BIN_W'(4)));
endmodule

bind ahb_burst_cov ahbcov_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_cnt(hit_cnt), .kind_cov(kind_cov),
  .pair_cov(pair_cov), .cov_total(cov_total)
);

// File: tb/tb_ahb_burst_cov.sv
module tb_ahb_burst_cov;
  import ahbcov_pkg::*;
  localparam int CLK_P = 10;
  localparam int W     = 3;
  localparam int MAXC  = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsel = 1'b0, hready = 1'b1, hwrite = 1'b0;
  logic [1:0] htrans = TR_IDLE, hresp = 2'b00;
  logic [2:0] hburst = 3'd0;
  logic [NKIND*W-1:0] hit_cnt;
  logic [NKIND-1:0]   kind_cov;
  logic [NCLS-1:0]    wait_cov, busy_cov;
  logic [NPAIR-1:0]   pair_cov;
  logic [BIN_W-1:0]   cov_total;

  int nchk = 0, nbad = 0;
  int exp_cnt[NKIND];
  int q[$];
  int last_seen[NKIND];
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  ahb_burst_cov #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans), .hready(hready),
    .hresp(hresp), .hburst(hburst), .hwrite(hwrite), .hit_cnt(hit_cnt),
    .kind_cov(kind_cov), .wait_cov(wait_cov), .busy_cov(busy_cov),
    .pair_cov(pair_cov), .cov_total(cov_total)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cnt_of(input int k);
    return int'(hit_cnt[k*W +: W]);
  endfunction

  // scoreboard monitor: every counter step must match the next expected kind
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < NKIND; k++) begin
        if (cnt_of(k) != last_seen[k]) begin
          if (q.size() == 0) begin
            chk("R3 unexpected completion kind", k, -1);
          end else begin
            int e;
            e = q.pop_front();
            chk("R2 completed kind", k, e);
            chk("R3 counter step", cnt_of(k), last_seen[k] + 1);
          end
          last_seen[k] = cnt_of(k);
        end
      end
    end
  end

  task automatic drive(input logic s, input logic [1:0] t, input logic r,
                       input logic [1:0] rsp, input logic [2:0] b, input logic w);
    @(negedge clk);
    hsel = s; htrans = t; hready = r; hresp = rsp; hburst = b; hwrite = w;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, TR_IDLE, 1'b1, 2'b00, 3'd0, 1'b0);
  endtask

  task automatic expect_kind(input int k);
    if (exp_cnt[k] < MAXC) begin
      exp_cnt[k]++;
      q.push_back(k);
    end
  endtask

  task automatic burst(input logic [2:0] hb, input logic w, input int nb,
                       input bit wt, input bit bz, input int kind);
    drive(1'b1, TR_NSEQ, 1'b1, 2'b00, hb, w);
    if (wt) drive(1'b1, (nb > 1) ? TR_SEQ : TR_IDLE, 1'b0, 2'b00, hb, w);
    if (bz && nb > 1) drive(1'b1, TR_BUSY, 1'b1, 2'b00, hb, w);
    for (int i = 1; i < nb; i++) drive(1'b1, TR_SEQ, 1'b1, 2'b00, hb, w);
    if (kind >= 0) expect_kind(kind);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog (R1..R12 run) actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NKIND; k++) begin exp_cnt[k] = 0; last_seen[k] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 counters", int'(|hit_cnt), 0);
    chk("R1 kind bitmap", int'(kind_cov), 0);
    chk("R1 total", int'(cov_total), 0);
    rst_n = 1'b1;
    idle(2);

    // R2 R3 single read
    burst(3'd0, 1'b0, 1, 0, 0, 0);
    idle(2);
    // R3 R11 four-beat write then eight-beat read back to back
    burst(3'd2, 1'b1, 4, 0, 0, 5);
    burst(3'd5, 1'b0, 8, 0, 0, 6);
    idle(2);
    chk("R11 pair 4-beat then 8-beat (bit 13)", int'(pair_cov[13]), 1);
    // R4 INCR write then sixteen-beat read
    burst(3'd1, 1'b1, 3, 0, 0, 3);
    burst(3'd7, 1'b0, 16, 0, 0, 8);
    idle(2);
    chk("R4 INCR write counted", cnt_of(3), 1);
    chk("R11 pair INCR then 16-beat (bit 9)", int'(pair_cov[9]), 1);
    // R9 single with wait
    burst(3'd0, 1'b0, 1, 1, 0, 0);
    idle(2);
    chk("R9 wait bin single", int'(wait_cov), 1);
    // R10 four-beat read with BUSY
    burst(3'd2, 1'b0, 4, 0, 1, 4);
    idle(2);
    chk("R10 busy bin 4-beat", int'(busy_cov), 4);
    // R5 error mid burst
    drive(1'b1, TR_NSEQ, 1'b1, 2'b00, 3'd4, 1'b1);
    drive(1'b1, TR_SEQ, 1'b1, 2'b00, 3'd4, 1'b1);
    drive(1'b1, TR_SEQ, 1'b1, 2'b00, 3'd4, 1'b1);
    drive(1'b1, TR_SEQ, 1'b0, 2'b01, 3'd4, 1'b1);
    drive(1'b1, TR_IDLE, 1'b1, 2'b01, 3'd0, 1'b0);
    idle(3);
    chk("R5 errored 8-beat write not counted", cnt_of(7), 0);
    chk("R5 errored kind not covered", int'(kind_cov[7]), 0);
    // R6 abandoned four-beat read followed by a single read
    drive(1'b1, TR_NSEQ, 1'b1, 2'b00, 3'd3, 1'b0);
    drive(1'b1, TR_SEQ, 1'b1, 2'b00, 3'd3, 1'b0);
    burst(3'd0, 1'b0, 1, 0, 0, 0);
    idle(2);
    chk("R6 abandoned 4-beat read not counted", cnt_of(4), 1);
    chk("R6 no pair from abandoned (bit 10)", int'(pair_cov[10]), 0);
    // R11 idle slot breaks chaining
    burst(3'd0, 1'b1, 1, 0, 0, 1);
    idle(1);
    burst(3'd0, 1'b1, 1, 0, 0, 1);
    idle(2);
    chk("R11 idle gap gives no pair (bit 0)", int'(pair_cov[0]), 0);
    burst(3'd0, 1'b1, 1, 0, 0, 1);
    burst(3'd0, 1'b1, 1, 0, 0, 1);
    idle(2);
    chk("R11 back-to-back singles pair (bit 0)", int'(pair_cov[0]), 1);
    // R7 saturation of single read
    for (int i = 0; i < 8; i++) burst(3'd0, 1'b0, 1, 0, 0, 0);
    idle(4);
    chk("R7 single read saturated", cnt_of(0), MAXC);
    chk("R7 scoreboard drained", q.size(), 0);
    for (int k = 0; k < NKIND; k++) begin
      chk("R3 final kind count", cnt_of(k), exp_cnt[k]);
      chk("R8 kind covered bit", int'(kind_cov[k]), (exp_cnt[k] != 0) ? 1 : 0);
    end
    chk("R8 kind bitmap", int'(kind_cov), 'h17B);
    chk("R9 final wait bins", int'(wait_cov), 1);
    chk("R10 final busy bins", int'(busy_cov), 4);
    chk("R11 final pair count", $countones(pair_cov), 3);
    chk("R12 total bins", int'(cov_total), 12);
    finished = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule